// File: doc/BRIEF.md
# Circular Buffer Address Corrector

This unit sits beside the pointer-update path of a processor's address generators. It gives circular-buffer behaviour to pointer arithmetic: when a bound pointer register steps past one edge of a buffer, the new address is folded back into the buffer. Software can then run tight loops over a ring of data without checking boundaries itself.

Two buffer descriptors exist, one for each data space. Slot 0 also serves program-space reads, which go through the first space. Each descriptor holds a first address, a last address, the pointer register it watches, an enable, and a preferred direction. Each cycle the unit takes one pointer update: the space, the register number, the old address and a signed step. One clock later it presents the corrected address.

A buffer whose length is a power of two and whose first address is aligned to that length is corrected at both edges. Any other buffer is corrected only in its configured direction, and only when its aligned edge is valid. The unit reports descriptors that cannot be honoured. It also warns when a descriptor watches one of the two stack-related registers.

Top module: `circbuf_addr_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `res_addr` becomes 0.
- R2: The corrected address for the inputs sampled at a rising edge appears on `res_addr` after that edge and stays there until the next edge.
- R3: An update whose register number differs from the selected descriptor's watched register, or whose descriptor has `desc_en` low, yields (old + sign-extended step) modulo 2^AW.
- R4: `upd_space` = 0 selects descriptor 0 and `upd_space` = 1 selects descriptor 1. A register bound only to the other descriptor is passed through.
- R5: For an active descriptor checked upward, a positive step whose sum exceeds the last address yields sum minus length. Length is last − first + 1.
- R6: For an active descriptor checked downward, a negative step whose sum falls below the first address yields sum plus length.
- R7: When the length is a power of two and the first address has its low log2(length) bits zero, both edges are checked, whatever `desc_down` says.
- R8: For any other active buffer, `desc_down` = 0 checks only the upper edge and `desc_down` = 1 checks only the lower edge. Steps in the opposite direction pass through unchanged.
- R9: Let M be the smallest value 2^k − 1 not below last − first. `cfg_err[i]` is high exactly when `desc_en[i]` is high and any one of the following holds: last < first; the buffer is not two-edged with `desc_down` = 0 and (first & M) ≠ 0; or the buffer is not two-edged with `desc_down` = 1 and (last & M) ≠ M. While `cfg_err[i]` is high, updates to that descriptor pass through as in R3.
- R10: `stack_warn[i]` is high exactly when `desc_en[i]` is high and `desc_reg[i]` is NREG−2 or NREG−1 (14 or 15 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_space | input | 1 | Data space of the update: 0 or 1 |
| upd_reg | input | RW | Pointer register number being updated |
| upd_addr | input | AW | Old pointer value |
| upd_mod | input | MW | Signed step, two's complement |
| desc_en | input | 2 | Per-descriptor enable |
| desc_down | input | 2 | Per-descriptor direction: 0 upward, 1 downward |
| desc_reg | input | 2×RW | Watched register per descriptor |
| desc_start | input | 2×AW | First address per descriptor |
| desc_end | input | 2×AW | Last address per descriptor |
| res_addr | output | AW | Corrected pointer value, registered |
| cfg_err | output | 2 | Descriptor cannot be honoured; wrapping is off |
| stack_warn | output | 2 | Descriptor watches a stack-related register |

## Verification
On every cycle the assertions check several things. Updates that touch no active descriptor pass through untouched. A step against a one-edge buffer's direction is never corrected. A two-edged buffer keeps an in-buffer pointer inside its bounds for any step no longer than the buffer. The two-edged classification always comes with an aligned last address. The exact folded values come only from the bench's sweeps: the length subtracted or added, which descriptor a given space and register reach, the precise `cfg_err` and `stack_warn` patterns, and the one-cycle timing. Those sweeps cover two-edged, upward-only, downward-only, misaligned, reversed and disabled descriptors.

// File: rtl/circbuf_pkg.sv
package circbuf_pkg;

    localparam int NSPACE = 2;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } circ_dir_e;

    typedef struct packed {
        logic ok;       // descriptor usable for correction
        logic chk_up;   // upper edge is checked
        logic chk_dn;   // lower edge is checked
    } desc_flags_t;

    // Spread the highest set bit downwards: gives 2^k-1 >= v
    function automatic logic [31:0] smear32(input logic [31:0] v);
        logic [31:0] r;
        r = v;
        r = r | (r >> 1);
        r = r | (r >> 2);
        r = r | (r >> 4);
        r = r | (r >> 8);
        r = r | (r >> 16);
        return r;
    endfunction

endpackage

// File: rtl/circbuf_desc_check.sv
module circbuf_desc_check
    import circbuf_pkg::*;
#(
    parameter int AW   = 16,
    parameter int NREG = 16,
    parameter int RW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          down,
    input  logic [RW-1:0] regn,
    input  logic [AW-1:0] start_a,
    input  logic [AW-1:0] end_a,
    output desc_flags_t   flags,
    output logic [AW:0]   len,
    output logic          err,
    output logic          warn
);

    localparam logic [RW-1:0] WARN_LO = RW'(NREG - 2);

    logic [AW-1:0] diff;
    logic [AW-1:0] mask;
    logic [31:0]   smeared;
    logic          ordered;
    logic          start_al;
    logic          end_al;
    logic          pow2;
    logic          bidir;
    logic          align_ok;

    always_comb begin
        diff     = end_a - start_a;
        smeared  = smear32(32'(diff));
        mask     = smeared[AW-1:0];
        ordered  = (end_a >= start_a);
        start_al = ((start_a & mask) == '0);
        end_al   = ((end_a & mask) == mask);
        pow2     = (diff == mask);
        bidir    = pow2 && start_al;
        align_ok = bidir || (circ_dir_e'(down) == DIR_DOWN ? end_al : start_al);

        flags.ok     = en && ordered && align_ok;
        flags.chk_up = flags.ok && (bidir || circ_dir_e'(down) == DIR_UP);
        flags.chk_dn = flags.ok && (bidir || circ_dir_e'(down) == DIR_DOWN);
        len          = {1'b0, diff} + 1'b1;
        err          = en && !(ordered && align_ok);
        warn         = en && (regn >= WARN_LO);
    end

    // A two-edged buffer must have its last address aligned as well
    AST_BIDIR_END_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (flags.chk_up && flags.chk_dn) |-> ((end_a & mask) == mask)); // R7

endmodule

// File: rtl/circbuf_wrap.sv
module circbuf_wrap #(
    parameter int AW = 16,
    parameter int MW = 8
) (
    input  logic [AW-1:0] old_a,
    input  logic [MW-1:0] step,
    input  logic [AW-1:0] start_a,
    input  logic [AW-1:0] end_a,
    input  logic [AW:0]   len,
    input  logic          chk_up,
    input  logic          chk_dn,
    output logic [AW-1:0] new_a
);

    localparam int SW = AW + 2;

    logic [SW-1:0] step_ext;
    logic [SW-1:0] sum;
    logic [SW-1:0] fixed;
    logic          step_pos;
    logic          step_neg;

    always_comb begin
        step_ext = {{(SW-MW){step[MW-1]}}, step};
        sum      = {2'b00, old_a} + step_ext;
        step_neg = step[MW-1];
        step_pos = !step[MW-1] && (step != '0);
        fixed    = sum;
        if (chk_up && step_pos && ($signed(sum) > $signed({2'b00, end_a})))
            fixed = sum - {1'b0, len};
        else if (chk_dn && step_neg && ($signed(sum) < $signed({2'b00, start_a})))
            fixed = sum + {1'b0, len};
        new_a = fixed[AW-1:0];
    end

endmodule

// File: rtl/circbuf_addr_unit.sv
module circbuf_addr_unit
    import circbuf_pkg::*;
#(
    parameter int AW   = 16,
    parameter int MW   = 8,
    parameter int NREG = 16,
    parameter int RW   = $clog2(NREG)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     upd_space,
    input  logic [RW-1:0]            upd_reg,
    input  logic [AW-1:0]            upd_addr,
    input  logic [MW-1:0]            upd_mod,
    input  logic [NSPACE-1:0]        desc_en,
    input  logic [NSPACE-1:0]        desc_down,
    input  logic [NSPACE-1:0][RW-1:0] desc_reg,
    input  logic [NSPACE-1:0][AW-1:0] desc_start,
    input  logic [NSPACE-1:0][AW-1:0] desc_end,
    output logic [AW-1:0]            res_addr,
    output logic [NSPACE-1:0]        cfg_err,
    output logic [NSPACE-1:0]        stack_warn
);

    desc_flags_t              flags [NSPACE];
    logic [NSPACE-1:0][AW:0]  lens;

    for (genvar i = 0; i < NSPACE; i++) begin : g_desc
        circbuf_desc_check #(.AW(AW), .NREG(NREG), .RW(RW)) i_check (
            .clk     (clk),
            .rst     (rst),
            .en      (desc_en[i]),
            .down    (desc_down[i]),
            .regn    (desc_reg[i]),
            .start_a (desc_start[i]),
            .end_a   (desc_end[i]),
            .flags   (flags[i]),
            .len     (lens[i]),
            .err     (cfg_err[i]),
            .warn    (stack_warn[i])
        );
    end

    desc_flags_t   sel_flags;
    logic [AW-1:0] sel_start;
    logic [AW-1:0] sel_end;
    logic [AW:0]   sel_len;
    logic          active;
    logic [AW-1:0] wrapped;

    always_comb begin
        sel_flags = flags[upd_space];
        sel_start = desc_start[upd_space];
        sel_end   = desc_end[upd_space];
        sel_len   = lens[upd_space];
        active    = sel_flags.ok && (upd_reg == desc_reg[upd_space]);
    end

    circbuf_wrap #(.AW(AW), .MW(MW)) i_wrap (
        .old_a   (upd_addr),
        .step    (upd_mod),
        .start_a (sel_start),
        .end_a   (sel_end),
        .len     (sel_len),
        .chk_up  (active && sel_flags.chk_up),
        .chk_dn  (active && sel_flags.chk_dn),
        .new_a   (wrapped)
    );

    always_ff @(posedge clk) begin
        if (rst) res_addr <= '0;
        else     res_addr <= wrapped;
    end

    // Observation terms for the properties below
    logic [AW-1:0] plain_sum;
    logic [MW-1:0] step_mag;
    logic          in_buf;
    logic          step_fits;

    always_comb begin
        plain_sum = upd_addr + {{(AW-MW){upd_mod[MW-1]}}, upd_mod};
        step_mag  = upd_mod[MW-1] ? (~upd_mod + 1'b1) : upd_mod;
        in_buf    = (upd_addr >= sel_start) && (upd_addr <= sel_end);
        step_fits = ({{(AW+1-MW){1'b0}}, step_mag} <= sel_len);
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (res_addr == '0)); // R1

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
        !active |=> (res_addr == $past(plain_sum))); // R3

    AST_NO_BACKWARD_FIX: assert property (@(posedge clk) disable iff (rst)
        (active && !sel_flags.chk_dn && upd_mod[MW-1]) |=> (res_addr == $past(plain_sum))); // R8

    AST_STAYS_IN_RING: assert property (@(posedge clk) disable iff (rst)
        (active && sel_flags.chk_up && sel_flags.chk_dn && in_buf && step_fits)
        |=> ((res_addr >= $past(sel_start)) && (res_addr <= $past(sel_end)))); // R7

endmodule

// File: tb/test_circbuf_addr_unit.sv
module test_circbuf_addr_unit;

    localparam int AW = 16;
    localparam int MW = 8;
    localparam int RW = 4;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                upd_space = 1'b0;
    logic [RW-1:0]       upd_reg = '0;
    logic [AW-1:0]       upd_addr = '0;
    logic [MW-1:0]       upd_mod = '0;
    logic [1:0]          desc_en = '0;
    logic [1:0]          desc_down = '0;
    logic [1:0][RW-1:0]  desc_reg = '0;
    logic [1:0][AW-1:0]  desc_start = '0;
    logic [1:0][AW-1:0]  desc_end = '0;
    logic [AW-1:0]       res_addr;
    logic [1:0]          cfg_err;
    logic [1:0]          stack_warn;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;   // 50 MHz

    circbuf_addr_unit #(.AW(AW), .MW(MW), .NREG(16), .RW(RW)) i_circbuf_addr_unit (
        .clk, .rst, .upd_space, .upd_reg, .upd_addr, .upd_mod,
        .desc_en, .desc_down, .desc_reg, .desc_start, .desc_end,
        .res_addr, .cfg_err, .stack_warn
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Descriptor evaluation from R7, R8, R9
    task automatic eval_desc(input int i, output bit ok, output bit up,
                             output bit dn, output bit err, output int len);
        int s, e, d, m;
        bit ordered, s_al, e_al, two, al_ok;
        s = int'(desc_start[i]);
        e = int'(desc_end[i]);
        ordered = (e >= s);
        d = ordered ? e - s : 0;
        m = 0;
        while (m < d) m = m * 2 + 1;
        s_al = ((s & m) == 0);
        e_al = ((e & m) == m);
        two  = ordered && (d == m) && s_al;
        al_ok = two || (desc_down[i] ? e_al : s_al);
        ok  = desc_en[i] && ordered && al_ok;
        err = desc_en[i] && !(ordered && al_ok);
        up  = ok && (two || !desc_down[i]);
        dn  = ok && (two || desc_down[i]);
        len = d + 1;
    endtask

    task automatic model(input int sp, input int rg, input int old, input int md,
                         output int res, output string tag);
        bit ok, up, dn, err, ok2, up2, dn2, err2;
        int len, len2, s;
        eval_desc(sp, ok, up, dn, err, len);
        eval_desc(1 - sp, ok2, up2, dn2, err2, len2);
        s = old + md;
        tag = "R3";
        if (rg == int'(desc_reg[sp]) && ok) begin
            if (md > 0 && up && s > int'(desc_end[sp])) begin
                s = s - len; tag = (up && dn) ? "R7" : "R5";
            end else if (md < 0 && dn && s < int'(desc_start[sp])) begin
                s = s + len; tag = (up && dn) ? "R7" : "R6";
            end else if ((md < 0 && !dn) || (md > 0 && !up)) begin
                tag = "R8";
            end else begin
                tag = "R2";
            end
        end else if (rg == int'(desc_reg[sp]) && err) begin
            tag = "R9";
        end else if (rg == int'(desc_reg[1 - sp]) && ok2) begin
            tag = "R4";
        end
        res = s & 16'hFFFF;
    endtask

    task automatic check_cfg();
        bit ok, up, dn, err;
        int len;
        #1;
        for (int i = 0; i < 2; i++) begin
            eval_desc(i, ok, up, dn, err, len);
            check("R9 cfg_err", int'(cfg_err[i]), int'(err));
            check("R10 stack_warn", int'(stack_warn[i]),
                  int'(desc_en[i] && desc_reg[i] >= 4'd14));
        end
    endtask

    task automatic set_desc(input int i, input bit en, input bit dn, input int rg,
                            input int s, input int e);
        desc_en[i]    = en;
        desc_down[i]  = dn;
        desc_reg[i]   = RW'(rg);
        desc_start[i] = AW'(s);
        desc_end[i]   = AW'(e);
    endtask

    task automatic sweep(input int lo, input int hi);
        int exp;
        string tag;
        int regs [3];
        int mods [10] = '{-7, -6, -4, -2, -1, 1, 2, 4, 6, 7};
        regs[0] = int'(desc_reg[0]);
        regs[1] = int'(desc_reg[1]);
        regs[2] = 5;
        for (int sp = 0; sp < 2; sp++)
            for (int r = 0; r < 3; r++)
                for (int a = lo; a <= hi; a++)
                    for (int k = 0; k < 10; k++) begin
                        @(negedge clk);
                        upd_space = sp[0];
                        upd_reg   = RW'(regs[r]);
                        upd_addr  = AW'(a);
                        upd_mod   = MW'(mods[k]);
                        model(sp, regs[r], a, mods[k], exp, tag);
                        @(negedge clk);
                        check(tag, int'(res_addr), exp);
                    end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset clears the output even with nonzero inputs
        upd_addr = 16'h1234;
        upd_mod  = 8'd3;
        repeat (3) @(negedge clk);
        check("R1 reset", int'(res_addr), 0);
        rst = 1'b0;
        // R2: no change before the edge, new value after it
        @(negedge clk);
        check("R1 first", int'(res_addr), 16'h1237);
        upd_addr = 16'hFFFF; upd_mod = 8'd2; upd_reg = 4'd5;
        #1 check("R2 hold", int'(res_addr), 16'h1237);
        @(negedge clk);
        check("R2 update", int'(res_addr), 16'h0001);

        // Scenario 1: two-edged ring in space 0, downward-only in space 1
        set_desc(0, 1, 0, 8, 16'h0040, 16'h004F);
        set_desc(1, 1, 1, 10, 16'h0086, 16'h008F);
        check_cfg();
        sweep(16'h003A, 16'h0053);
        sweep(16'h0080, 16'h0093);

        // Scenario 2: upward-only in space 0, two-edged (down set) in space 1
        set_desc(0, 1, 0, 9, 16'h0060, 16'h006B);
        set_desc(1, 1, 1, 11, 16'h0080, 16'h008F);
        check_cfg();
        sweep(16'h005A, 16'h0072);
        sweep(16'h007A, 16'h0094);

        // Scenario 3: misaligned start, disabled descriptor on reg 15
        set_desc(0, 1, 0, 9, 16'h0062, 16'h006B);
        set_desc(1, 0, 0, 15, 16'h0080, 16'h008F);
        check_cfg();
        sweep(16'h005E, 16'h0070);

        // Scenario 4: reversed bounds, stack registers, misaligned downward end
        set_desc(0, 1, 0, 14, 16'h0050, 16'h0040);
        set_desc(1, 1, 1, 15, 16'h0086, 16'h008E);
        check_cfg();
        sweep(16'h0082, 16'h0090);

        // Scenario 5: two-edged ring on stack register, same reg in both slots
        set_desc(0, 1, 1, 15, 16'h0000, 16'h0007);
        set_desc(1, 1, 0, 15, 16'hFFF8, 16'hFFFF);
        check_cfg();
        sweep(16'h0000, 16'h0009);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule